// File: doc/BRIEF.md
# Tagged ADC Result Buffer

This block is a first-in first-out store that sits between a successive-approximation converter and a host-facing read path. Each time a conversion completes, the producer presents a 12-bit result together with a one-bit source tag and a write strobe. The store keeps up to 64 such entries in arrival order.

The consumer pops one entry per single-cycle read strobe. One cycle later it sees a registered 16-bit word. The word carries the result right-justified and its tag. It also carries two status bits that are evaluated as part of that read, so software polling the word learns the buffer state without a separate status access.

Occupancy is tracked by a three-state controller. **ST_EMPTY** holds no unread entry. **ST_PARTIAL** holds between 1 and 63. **ST_FULL** holds 64. The transitions are:
- **EMPTY→PARTIAL** on an accepted write.
- **PARTIAL→EMPTY** on a read that removes the last entry with no write in the same cycle.
- **PARTIAL→FULL** on a write that fills the 64th slot with no read.
- **FULL→PARTIAL** on any read.

All other cycles stay in place. A write in ST_FULL is refused, and a read in ST_EMPTY pops nothing.

Top module: `tagged_result_buffer`

## Requirements
- R1: Results are returned in the order they were written, and up to 64 entries can be held at once.
- R2: The read word is laid out as follows: bit 15 is the full flag, bit 14 is the empty flag, bit 13 is reserved and always 0, bit 12 is the source tag, and bits 11:0 are the result, right-justified.
- R3: Bit 15 of a read word is 1 exactly when all 64 locations held unread data at the moment of that read; otherwise it is 0.
- R4: Bit 14 of a read word is 1 when no unread entry remains after that read, including the read that removes the last stored entry. It is 0 while entries remain.
- R5: After reset, the read word is 0x4000 (full flag 0, empty flag 1) and the buffer holds no entries.
- R6: The tag supplied with each write is returned unchanged in bit 12 of that entry's read word. Tag 0 marks X, Z1, battery or AUX2 results, and tag 1 marks Y, Z2, AUX1 or temperature results.
- R7: A write presented while 64 entries are held is dropped, even if a read occurs in the same cycle, and every stored entry is left intact.
- R8: A read while the buffer is empty returns 0x4000 and moves no pointer, so the next written entry is the next one returned.
- R9: A read and a write in the same cycle, while the buffer is neither full nor empty, leave the occupancy unchanged.
- R10: The read word is registered. It changes only on the clock edge that samples a read strobe and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Conversion-complete strobe; stores one entry |
| wr_tag | input | 1 | Source tag of the incoming result |
| wr_data | input | 12 | Incoming converter result |
| rd_en | input | 1 | Single-cycle read strobe; pops one entry |
| rd_word | output | 16 | Registered read word: full, empty, reserved, tag, result |

## Verification
The hardest corner to reach from the ports is the full buffer with a read and a write in the same cycle. Here the write must be refused while the read still reports the full flag. Reaching it takes 64 back-to-back writes, then a lone write at full, then a combined read and write. The stimulus then drains all 63 remaining entries with distinct values, so that any leak of a refused result shows up as an ordering error. The empty-buffer read followed at once by a write is also driven, to show that the pointers did not move.

// File: rtl/trb_pkg.sv
package trb_pkg;
    localparam int RES_W   = 12;
    localparam int WORD_W  = 16;
    localparam int ENTRY_W = RES_W + 1;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

    typedef struct packed {
        logic             full;
        logic             empty;
        logic             rsvd;
        logic             tag;
        logic [RES_W-1:0] res;
    } rd_word_t;

    localparam rd_word_t IDLE_WORD = '{full: 1'b0, empty: 1'b1, rsvd: 1'b0,
                                       tag: 1'b0, res: '0};
endpackage

// File: rtl/trb_ctrl.sv
module trb_ctrl
    import trb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             do_push,
    output logic             do_pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full_pre,
    output logic             empty_post,
    output logic [CNT_W-1:0] occ,
    output occ_state_t       state
);
    occ_state_t       state_nx;
    logic [CNT_W-1:0] occ_nx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state and output decode
    always_comb begin
        do_push    = wr_en && (state != ST_FULL);
        do_pop     = rd_en && (state != ST_EMPTY);
        occ_nx     = occ + CNT_W'(do_push) - CNT_W'(do_pop);
        full_pre   = (state == ST_FULL);
        empty_post = (occ_nx == '0);
        state_nx   = state;
        unique case (state)
            ST_EMPTY:   if (do_push) state_nx = ST_PARTIAL;
            ST_PARTIAL: begin
                if (occ_nx == '0)                 state_nx = ST_EMPTY;
                else if (occ_nx == CNT_W'(DEPTH)) state_nx = ST_FULL;
            end
            ST_FULL:    if (do_pop) state_nx = ST_PARTIAL;
            default:    state_nx = ST_EMPTY;
        endcase
    end

    // state register, occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            occ    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
        end
    end
endmodule

// File: rtl/trb_mem.sv
module trb_mem
    import trb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [PTR_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);
    logic [ENTRY_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/trb_outreg.sv
module trb_outreg
    import trb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               do_pop,
    input  logic               full_pre,
    input  logic               empty_post,
    input  logic [ENTRY_W-1:0] entry,
    output rd_word_t           word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= IDLE_WORD;
        end else if (rd_en) begin
            if (do_pop) begin
                word_q.full  <= full_pre;
                word_q.empty <= empty_post;
                word_q.rsvd  <= 1'b0;
                word_q.tag   <= entry[RES_W];
                word_q.res   <= entry[RES_W-1:0];
            end else begin
                word_q <= IDLE_WORD;
            end
        end
    end
endmodule

// File: rtl/tagged_result_buffer.sv
module tagged_result_buffer
    import trb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tag,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word
);
    logic               do_push, do_pop, full_pre, empty_post;
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   occ;
    occ_state_t         state;
    logic [ENTRY_W-1:0] head;
    rd_word_t           word_q;

    trb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .full_pre   (full_pre),
        .empty_post (empty_post),
        .occ        (occ),
        .state      (state)
    );

    trb_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr),
        .wdata ({wr_tag, wr_data}),
        .raddr (rd_ptr),
        .rdata (head)
    );

    trb_outreg u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .do_pop     (do_pop),
        .full_pre   (full_pre),
        .empty_post (empty_post),
        .entry      (head),
        .word_q     (word_q)
    );

    assign rd_word = word_q;
endmodule

// File: rtl/trb_checker.sv
module trb_checker
    import trb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_word,
    input logic [CNT_W-1:0]  occ,
    input occ_state_t        state
);
    p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[13] == 1'b0);

    p_full_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state == ST_FULL) |=> rd_word[15]);

    p_empty_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && occ == CNT_W'(1)) |=> rd_word[14]);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && occ == CNT_W'(DEPTH)) |=> occ == CNT_W'(DEPTH));

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |=> rd_word == 16'h4000);

    p_occ_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && occ != '0 && occ != CNT_W'(DEPTH)) |=> $stable(occ));

    p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_word));
endmodule

bind tagged_result_buffer trb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_word (rd_word),
    .occ     (occ),
    .state   (state)
);

// File: tb/tagged_result_buffer_tb.sv
`timescale 1ns/1ps
module tagged_result_buffer_tb;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_tag = 1'b0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_word;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] w;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [12:0] model_q[$];
    logic        pend = 1'b0;

    always #2 clk = ~clk;

    tagged_result_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_word (rd_word)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the read word
    task automatic step(input bit wr, input bit tg, input logic [11:0] d,
                        input bit rd, input string req);
        int          pre;
        logic [12:0] e;
        bit          popped;
        @(posedge clk);
        #1;
        wr_en   = wr;
        wr_tag  = tg;
        wr_data = d;
        rd_en   = rd;
        pre     = model_q.size();
        popped  = 1'b0;
        e       = '0;
        if (rd && pre > 0) begin
            e      = model_q.pop_front();
            popped = 1'b1;
        end
        if (wr && pre < DEPTH) model_q.push_back({tg, d});
        if (rd) begin
            exp_t x;
            x.req = req;
            if (popped) x.w = {pre == DEPTH, model_q.size() == 0, 1'b0, e};
            else        x.w = 16'h4000;
            exp_q.push_back(x);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, "");
    endtask

    // monitor: compares each registered read word with the scoreboard
    always @(posedge clk) pend <= rd_en;

    always @(negedge clk) begin
        if (rst_n && pend) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10: actual %h expected no read word", rd_word);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(rd_word, x.w, x.req);
            end
        end
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_word, 16'h4000, "R5 reset word");
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: read on an empty buffer, then a write/read proves no pointer moved
        step(0, 0, '0, 1, "R8 empty read");
        step(0, 0, '0, 1, "R8 second empty read");
        step(1, 1, 12'h5A5, 0, "");
        step(0, 0, '0, 1, "R8 next write returned");
        // R8/R4: combined read+write on empty returns idle word, entry kept
        step(1, 0, 12'h0F1, 1, "R8 read+write on empty");
        step(0, 0, '0, 1, "R4 last entry sets empty");

        // R2/R6: tags and layout, R4 on the final pop
        step(1, 0, 12'hABC, 0, "");
        step(1, 1, 12'h123, 0, "");
        step(1, 1, 12'hFFF, 0, "");
        step(0, 0, '0, 1, "R6 tag 0 layout R2");
        step(0, 0, '0, 1, "R6 tag 1 layout R2");
        step(0, 0, '0, 1, "R4 empty on last");
        idle(2);

        // R10: word holds while no read
        held = 16'h5FFF;
        idle(4);
        @(negedge clk);
        check(rd_word, held, "R10 hold without read");

        // R9: concurrent read+write keeps occupancy at five
        for (int i = 0; i < 5; i++) step(1, i[0], 12'(100 + i), 0, "");
        for (int i = 0; i < 10; i++) step(1, i[1], 12'(200 + i), 1, "R9 steady occupancy");
        for (int i = 0; i < 5; i++) step(0, 0, '0, 1, "R9 drain R4");

        // R1/R3/R7: fill to 64, overfill, read+write at full, drain
        for (int i = 0; i < DEPTH; i++) step(1, i[2], 12'(i * 37 + 11), 0, "");
        step(1, 1, 12'hEEE, 0, "");
        step(1, 0, 12'hDDD, 1, "R3 full flag R7 drop");
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, '0, 1, "R1 order R7 intact");
        step(0, 0, '0, 1, "R8 read after drain");

        idle(4);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule